// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Engine

This block is a bus-master DMA engine that moves 16-bit words between system memory and a storage device port. Software places a table of descriptors in memory. Each descriptor occupies 8 bytes and names one buffer. Software writes the table start address and a direction, then sets the run bit. From then on the engine walks the table without further help. It reads each descriptor over a simple request/acknowledge memory port. It streams the buffer one word at a time, paced by the device's request line, and acknowledges each word back to the device. It stops after the descriptor that carries the end-of-table flag.

Descriptors are fetched from memory at the moment they are needed and are never kept across runs, so software may rewrite the table between runs. The engine records two failures in its status register: an error from the memory port, and a device that still asks for data after the table is exhausted. It also records an interrupt from the device. Both of these status flags stay set until software writes a 1 to them.

Top module: `sg_dma_engine`

## Requirements
- R1: After reset the command, status and table-address registers read 0, and `mem_req` and `dev_ack` are low.
- R2: The table-address register (offset 2) stores the written value with bits [1:0] forced to zero. A run fetches descriptor word 0 at that address first and descriptor word 1 at that address plus 4.
- R3: In descriptor word 0, bits [31:2] give the buffer address (bits [1:0] are ignored). In word 1, bits [15:0] give the byte count (bit 0 is ignored) and bit 31 marks the last descriptor. The next descriptor is read 8 bytes after the previous one, and it is re-read from memory on every run.
- R4: A byte count of 0 stands for 65536 bytes. Such a descriptor does not finish early and raises no error while the device keeps supplying words.
- R5: Each word costs one memory access and one single-cycle `dev_ack` pulse. A pulse follows only an error-free memory acknowledge. The buffer address rises by 2 and the remaining count falls by 2 per word.
- R6: Command bit 3 = 0 reads memory and presents the word on `dev_wdata`. Command bit 3 = 1 writes `dev_rdata` into memory.
- R7: After the last word of the flagged descriptor the engine goes idle and fetches no further descriptor.
- R8: Status bit 0 reads 1 exactly while the engine is busy. It ignores writes. The memory port and `dev_ack` stay quiet while it is 0.
- R9: If `dev_req` is still high in the cycle after the final word, status bit 1 (error) is set and the engine stops.
- R10: A memory access that returns `mem_err` sets status bit 1 and stops the engine without acknowledging that word.
- R11: A cycle with `dev_irq` high sets status bit 2 (interrupt).
- R12: Status bits 1 and 2 clear only when a 1 is written to them; writing 0 leaves them set.
- R13: Writing command bit 0 to 0 idles the engine at the next word boundary. Writing it back to 1 restarts the walk from the table address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 table address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DEV_W | Memory write data |
| mem_rdata | input | 32 | Memory read data (descriptor word or data in low bits) |
| mem_ack | input | 1 | Memory access complete |
| mem_err | input | 1 | Memory access failed (valid with `mem_ack`) |
| dev_req | input | 1 | Device wants a word moved |
| dev_ack | output | 1 | One word moved this cycle |
| dev_rdata | input | DEV_W | Word from the device |
| dev_wdata | output | DEV_W | Word to the device |
| dev_irq | input | 1 | Device interrupt |

## Verification
The assertions check several properties on every cycle. `dev_ack` is a single-cycle pulse that follows a clean memory acknowledge. Buffer and descriptor addresses keep their alignment. The count never steps below one word. An idle engine stays off the memory port. Every detected error stops the engine, and the error and interrupt flags stay set until a 1 is written to them. Other behaviour only shows up across whole runs, so the bench scenarios must cover it:
- the order and addresses of descriptor fetches;
- the data landing in the right buffer words in each direction;
- a zero count standing for 64 KB;
- stopping and restarting from the table address;
- the end-of-table overrun that raises the error flag.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DESC_LO,
      ST_DESC_HI,
      ST_WAIT,
      ST_MEM,
      ST_ACK,
      ST_END
   } walk_state_t;

   localparam logic [1:0] RA_CMD  = 2'd0;
   localparam logic [1:0] RA_STAT = 2'd1;
   localparam logic [1:0] RA_TBL  = 2'd2;

   localparam int CMD_RUN_BIT = 0;
   localparam int CMD_DIR_BIT = 3;
   localparam int ST_ACT_BIT  = 0;
   localparam int ST_ERR_BIT  = 1;
   localparam int ST_IRQ_BIT  = 2;
   localparam int LAST_BIT    = 31;
   localparam int DESC_BYTES  = 8;
endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
   import sgdma_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  logic              err_set,
   input  logic              irq_in,
   output logic              run,
   output logic              dir,
   output logic              launch,
   output logic [ADDR_W-1:0] tbl_base
);
   logic              run_q, dir_q, err_q, irq_q;
   logic [ADDR_W-1:0] base_q;
   logic              wr_cmd, wr_stat, wr_tbl;
   logic [31:0]       rd_mux;
   logic              unused_wd;

   initial begin
      assert (ADDR_W >= 12 && ADDR_W <= 32)
         else $error("sgdma_regs: ADDR_W out of range");
   end

   assign unused_wd = ^reg_wdata;
   assign wr_cmd  = reg_we && (reg_addr == RA_CMD);
   assign wr_stat = reg_we && (reg_addr == RA_STAT);
   assign wr_tbl  = reg_we && (reg_addr == RA_TBL);
   assign launch  = wr_cmd && reg_wdata[CMD_RUN_BIT] && !run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         dir_q  <= 1'b0;
         err_q  <= 1'b0;
         irq_q  <= 1'b0;
         base_q <= '0;
      end else begin
         if (wr_cmd) begin
            run_q <= reg_wdata[CMD_RUN_BIT];
            dir_q <= reg_wdata[CMD_DIR_BIT];
         end
         if (wr_tbl)
            base_q <= {reg_wdata[ADDR_W-1:2], 2'b00};
         if (err_set)
            err_q <= 1'b1;
         else if (wr_stat && reg_wdata[ST_ERR_BIT])
            err_q <= 1'b0;
         if (irq_in)
            irq_q <= 1'b1;
         else if (wr_stat && reg_wdata[ST_IRQ_BIT])
            irq_q <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         RA_CMD: begin
            rd_mux[CMD_RUN_BIT] = run_q;
            rd_mux[CMD_DIR_BIT] = dir_q;
         end
         RA_STAT: begin
            rd_mux[ST_ACT_BIT] = busy;
            rd_mux[ST_ERR_BIT] = err_q;
            rd_mux[ST_IRQ_BIT] = irq_q;
         end
         RA_TBL:  rd_mux[ADDR_W-1:0] = base_q;
         default: rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_flop
         logic [31:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign reg_rdata = rd_q;
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate

   assign run      = run_q;
   assign dir      = dir_q;
   assign tbl_base = base_q;

   assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(wr_stat && reg_wdata[ST_ERR_BIT])) |=> err_q);
   assert_irq_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !(wr_stat && reg_wdata[ST_IRQ_BIT])) |=> irq_q);
   assert_irq_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_in |=> irq_q);
   assert_err_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> err_q);
endmodule

// File: rtl/sgdma_stepper.sv
module sgdma_stepper #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_addr,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              load_cnt,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic              step,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              last_word
);
   localparam int RW = CNT_W + 1;
   localparam logic [CNT_W-1:0] LOW_MASK = CNT_W'(STEP - 1);
   localparam logic [RW-1:0]    FULL     = RW'(1) << CNT_W;

   logic [ADDR_W-1:0] addr_q;
   logic [RW-1:0]     remain_q;
   logic [CNT_W-1:0]  cnt_even;

   assign cnt_even = cnt_in & ~LOW_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         remain_q <= '0;
      end else begin
         if (load_addr)
            addr_q <= addr_in;
         else if (step)
            addr_q <= addr_q + ADDR_W'(STEP);
         if (load_cnt)
            remain_q <= (cnt_even == '0) ? FULL : {1'b0, cnt_even};
         else if (step)
            remain_q <= remain_q - RW'(STEP);
      end
   end

   assign cur_addr  = addr_q;
   assign last_word = (remain_q == RW'(STEP));

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (remain_q >= RW'(STEP)));
   assert_step_addr_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (addr_q[0] == 1'b0) || $past(load_addr));
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
   import sgdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int DEV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              dir,
   input  logic              launch,
   input  logic [ADDR_W-1:0] tbl_base,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DEV_W-1:0]  mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic              dev_req,
   output logic              dev_ack,
   input  logic [DEV_W-1:0]  dev_rdata,
   output logic [DEV_W-1:0]  dev_wdata,
   output logic              busy,
   output logic              err_set
);
   localparam int STEP = DEV_W / 8;

   walk_state_t       st, nxt;
   logic [ADDR_W-1:0] ptr_q;
   logic              last_q;
   logic [DEV_W-1:0]  data_q;
   logic              ld_addr, ld_cnt, stp, last_word;
   logic [ADDR_W-1:0] cur_addr, buf_ptr;
   logic              mem_ok, unused_rd;

   initial begin
      assert (DEV_W == 16 || DEV_W == 32)
         else $error("sgdma_walker: DEV_W must be 16 or 32");
      assert (CNT_W >= 4 && CNT_W <= 30)
         else $error("sgdma_walker: CNT_W must leave the last-descriptor bit free");
   end

   assign unused_rd = ^mem_rdata;
   assign mem_ok  = mem_ack && !mem_err;
   assign buf_ptr = {mem_rdata[ADDR_W-1:2], 2'b00};

   sgdma_stepper #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) i_stepper (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_addr (ld_addr),
      .addr_in   (buf_ptr),
      .load_cnt  (ld_cnt),
      .cnt_in    (mem_rdata[CNT_W-1:0]),
      .step      (stp),
      .cur_addr  (cur_addr),
      .last_word (last_word)
   );

   always_comb begin
      nxt     = st;
      ld_addr = 1'b0;
      ld_cnt  = 1'b0;
      stp     = 1'b0;
      case (st)
         ST_IDLE:    if (launch) nxt = ST_DESC_LO;
         ST_DESC_LO: if (mem_ack) begin
                        nxt     = mem_err ? ST_IDLE : ST_DESC_HI;
                        ld_addr = !mem_err;
                     end
         ST_DESC_HI: if (mem_ack) begin
                        nxt    = mem_err ? ST_IDLE : ST_WAIT;
                        ld_cnt = !mem_err;
                     end
         ST_WAIT:    if (!run)        nxt = ST_IDLE;
                     else if (dev_req) nxt = ST_MEM;
         ST_MEM:     if (mem_ack) nxt = mem_err ? ST_IDLE : ST_ACK;
         ST_ACK: begin
            stp = 1'b1;
            if (last_word) nxt = last_q ? ST_END : ST_DESC_LO;
            else           nxt = ST_WAIT;
         end
         ST_END:     nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ptr_q  <= '0;
         last_q <= 1'b0;
         data_q <= '0;
      end else begin
         st <= nxt;
         if (st == ST_IDLE && launch)
            ptr_q <= tbl_base;
         if (st == ST_DESC_HI && mem_ok) begin
            ptr_q  <= ptr_q + ADDR_W'(DESC_BYTES);
            last_q <= mem_rdata[LAST_BIT];
         end
         if (st == ST_MEM && mem_ok && !dir)
            data_q <= mem_rdata[DEV_W-1:0];
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_addr = '0;
      case (st)
         ST_DESC_LO: begin mem_req = 1'b1; mem_addr = ptr_q;              end
         ST_DESC_HI: begin mem_req = 1'b1; mem_addr = ptr_q + ADDR_W'(4); end
         ST_MEM:     begin mem_req = 1'b1; mem_addr = cur_addr;           end
         default:    ;
      endcase
   end

   assign mem_we    = (st == ST_MEM) && dir;
   assign mem_wdata = dev_rdata;
   assign dev_ack   = (st == ST_ACK);
   assign dev_wdata = data_q;
   assign busy      = (st != ST_IDLE);
   assign err_set   = (mem_req && mem_ack && mem_err) || (st == ST_END && dev_req);

   assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |=> !dev_ack);
   assert_ack_after_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dev_ack |-> $past(mem_req && mem_ack && !mem_err));
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !dev_ack));
   assert_desc_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && (st != ST_MEM)) |-> (mem_addr[1:0] == 2'b00));
   assert_error_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> !busy);
endmodule

// File: rtl/sg_dma_engine.sv
module sg_dma_engine
   import sgdma_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int CNT_W    = 16,
   parameter int DEV_W    = 16,
   parameter bit READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DEV_W-1:0]  mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic              dev_req,
   output logic              dev_ack,
   input  logic [DEV_W-1:0]  dev_rdata,
   output logic [DEV_W-1:0]  dev_wdata,
   input  logic              dev_irq
);
   logic              run, dir, launch, busy, err_set;
   logic [ADDR_W-1:0] tbl_base;

   sgdma_regs #(.ADDR_W(ADDR_W), .READ_REG(READ_REG)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy),
      .err_set   (err_set),
      .irq_in    (dev_irq),
      .run       (run),
      .dir       (dir),
      .launch    (launch),
      .tbl_base  (tbl_base)
   );

   sgdma_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W)) i_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .dir       (dir),
      .launch    (launch),
      .tbl_base  (tbl_base),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .mem_err   (mem_err),
      .dev_req   (dev_req),
      .dev_ack   (dev_ack),
      .dev_rdata (dev_rdata),
      .dev_wdata (dev_wdata),
      .busy      (busy),
      .err_set   (err_set)
   );
endmodule

// File: tb/test_sg_dma_engine.sv
module test_sg_dma_engine;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_we;
   logic [1:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        mem_req, mem_we, mem_ack, mem_err;
   logic [31:0] mem_addr, mem_rdata;
   logic [15:0] mem_wdata, dev_rdata, dev_wdata;
   logic        dev_req, dev_ack, dev_irq;

   always #5 clk = ~clk;

   sg_dma_engine i_sg_dma_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
      .dev_req(dev_req), .dev_ack(dev_ack), .dev_rdata(dev_rdata),
      .dev_wdata(dev_wdata), .dev_irq(dev_irq)
   );

   int n_tests = 0;
   int n_fail  = 0;

   // memory model: 4 KB of halfwords, immediate acknowledge
   logic [15:0] mem16 [0:2047];
   logic        bk_we;
   logic [10:0] bk_idx;
   logic [15:0] bk_data;
   logic        err_en;
   logic [31:0] err_addr;
   wire  [10:0] m_idx = mem_addr[11:1];

   assign mem_ack   = mem_req;
   assign mem_rdata = {mem16[m_idx + 11'd1], mem16[m_idx]};
   assign mem_err   = mem_req && err_en && (mem_addr == err_addr);

   always @(posedge clk) begin
      if (bk_we) mem16[bk_idx] <= bk_data;
      else if (mem_req && mem_we && !mem_err) mem16[m_idx] <= mem_wdata;
   end

   // device model and logs
   int          ack_cnt, dev_total, desc_rd_cnt, data_bad, cur_half0;
   logic [31:0] first_desc, last_desc, cur_buf0, cur_buf1;
   logic        cur_dir, clr;

   function automatic logic [15:0] pat(input logic [31:0] a);
      return 16'hA000 ^ a[15:0];
   endfunction

   function automatic logic [31:0] exp_addr(input int k);
      if (k < cur_half0) return cur_buf0 + 32'(2 * k);
      return cur_buf1 + 32'(2 * (k - cur_half0));
   endfunction

   assign dev_req   = (ack_cnt < dev_total);
   assign dev_rdata = 16'h5000 + 16'(ack_cnt);

   always @(posedge clk) begin
      if (clr) begin
         ack_cnt     <= 0;
         desc_rd_cnt <= 0;
         data_bad    <= 0;
      end else begin
         if (dev_ack) begin
            ack_cnt <= ack_cnt + 1;
            if (!cur_dir && dev_wdata != pat(exp_addr(ack_cnt)))
               data_bad <= data_bad + 1;
         end
         if (mem_req && !mem_we && mem_addr < 32'h400) begin
            if (desc_rd_cnt == 0) first_desc <= mem_addr;
            last_desc   <= mem_addr;
            desc_rd_cnt <= desc_rd_cnt + 1;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic bk_write(input logic [31:0] a, input logic [15:0] d);
      @(negedge clk);
      bk_we = 1'b1; bk_idx = a[11:1]; bk_data = d;
      @(posedge clk);
      #1 bk_we = 1'b0;
   endtask

   task automatic put_desc(input logic [31:0] at, input logic [31:0] ptr,
                           input logic [15:0] cnt, input logic last);
      bk_write(at,      ptr[15:0]);
      bk_write(at + 2,  ptr[31:16]);
      bk_write(at + 4,  cnt);
      bk_write(at + 6,  {last, 15'd0});
   endtask

   task automatic fill(input logic [31:0] base, input int nbytes);
      for (int k = 0; k < nbytes; k += 2) bk_write(base + 32'(k), pat(base + 32'(k)));
   endtask

   task automatic clear_logs();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] s;
      bit done = 0;
      for (int k = 0; k < 3000 && !done; k++) begin
         reg_read(2'd1, s);
         if (!s[0]) done = 1;
      end
      chk(req, 32'(done), 32'd1);
   endtask

   task automatic start(input logic d);
      reg_write(2'd0, {28'd0, d, 3'b000});
      reg_write(2'd0, {28'd0, d, 3'b001});
   endtask

   // {dir, single, cnt0[7:0], cnt1[7:0], extra device words[6:0]}
   localparam logic [24:0] VEC [5] = '{
      {1'b0, 1'b0, 8'd8,  8'd4,  7'd0},
      {1'b1, 1'b0, 8'd6,  8'd10, 7'd0},
      {1'b0, 1'b0, 8'd4,  8'd4,  7'd2},
      {1'b1, 1'b1, 8'd12, 8'd0,  7'd1},
      {1'b1, 1'b1, 8'd2,  8'd0,  7'd0}
   };

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      bk_we = 1'b0; bk_idx = '0; bk_data = '0; err_en = 1'b0; err_addr = '0;
      dev_irq = 1'b0; dev_total = 0; clr = 1'b1; cur_dir = 1'b0;
      cur_half0 = 0; cur_buf0 = '0; cur_buf1 = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); clr = 1'b0;

      // R1 reset state
      reg_read(2'd0, r); chk("R1 cmd", r, 32'd0);
      reg_read(2'd1, r); chk("R1 status", r, 32'd0);
      reg_read(2'd2, r); chk("R1 table", r, 32'd0);
      chk("R1 mem_req", 32'(mem_req), 32'd0);
      chk("R1 dev_ack", 32'(dev_ack), 32'd0);

      // R2 table address alignment
      reg_write(2'd2, 32'h0000_010B);
      reg_read(2'd2, r); chk("R2 table masked", r, 32'h108);

      // R8 active bit ignores writes
      reg_write(2'd1, 32'h1);
      reg_read(2'd1, r); chk("R8 active write ignored", 32'(r[0]), 32'd0);

      // vector table walk
      for (int i = 0; i < 5; i++) begin
         logic        d, single;
         int          c0, c1, ex, words, nd, bad;
         logic [31:0] tbl;
         d = VEC[i][24]; single = VEC[i][23];
         c0 = int'(VEC[i][22:15]); c1 = int'(VEC[i][14:7]); ex = int'(VEC[i][6:0]);
         if (single) c1 = 0;
         words = (c0 + c1) / 2;
         nd = single ? 1 : 2;
         tbl = 32'h100 + 32'(i * 32);
         reg_write(2'd1, 32'h6);
         reg_write(2'd0, 32'h0);
         reg_write(2'd2, tbl);
         put_desc(tbl, 32'h401, 16'(c0), single);
         if (!single) put_desc(tbl + 8, 32'h603, 16'(c1), 1'b1);
         fill(32'h400, c0);
         fill(32'h600, c1);
         cur_buf0 = 32'h400; cur_buf1 = 32'h600; cur_half0 = c0 / 2; cur_dir = d;
         dev_total = words + ex;
         clear_logs();
         start(d);
         wait_idle("R7 run completes");
         chk("R5 R7 words moved", 32'(ack_cnt), 32'(words));
         reg_read(2'd1, r);
         chk("R9 error on overrun", 32'(r[1]), 32'(ex != 0));
         chk("R7 descriptor reads", 32'(desc_rd_cnt), 32'(2 * nd));
         chk("R2 first fetch at table", first_desc, tbl);
         chk("R3 last fetch address", last_desc, tbl + 32'(8 * (nd - 1) + 4));
         bad = 0;
         if (d) begin
            for (int k = 0; k < words; k++)
               if (mem16[exp_addr(k) >> 1] !== 16'h5000 + 16'(k)) bad++;
         end else bad = data_bad;
         chk("R6 data path", 32'(bad), 32'd0);
      end

      // R4 zero count = 64 KB, then R13 stop at word boundary
      reg_write(2'd1, 32'h6);
      reg_write(2'd0, 32'h0);
      reg_write(2'd2, 32'h300);
      put_desc(32'h300, 32'h400, 16'd0, 1'b1);
      fill(32'h400, 16);
      cur_buf0 = 32'h400; cur_half0 = 32768; cur_dir = 1'b0; dev_total = 6;
      clear_logs();
      start(1'b0);
      for (int k = 0; k < 200 && ack_cnt < 6; k++) @(posedge clk);
      repeat (10) @(posedge clk);
      reg_read(2'd1, r);
      chk("R4 zero count still active", 32'(r[0]), 32'd1);
      chk("R4 zero count no error", 32'(r[1]), 32'd0);
      chk("R5 address stepping data", 32'(data_bad), 32'd0);
      reg_write(2'd0, 32'h0);
      repeat (5) @(posedge clk);
      reg_read(2'd1, r);
      chk("R13 stop goes idle", 32'(r[0]), 32'd0);
      chk("R13 no words after stop", 32'(ack_cnt), 32'd6);

      // R13 restart from table base, R3 re-read descriptor and odd count
      put_desc(32'h300, 32'h500, 16'd5, 1'b1);
      fill(32'h500, 4);
      cur_buf0 = 32'h500; cur_half0 = 2; dev_total = 2;
      clear_logs();
      reg_write(2'd0, 32'h1);
      wait_idle("R13 restart completes");
      chk("R13 restart at table", first_desc, 32'h300);
      chk("R3 count bit0 ignored", 32'(ack_cnt), 32'd2);
      reg_read(2'd1, r);
      chk("R3 fresh descriptor no error", 32'(r[1]), 32'd0);
      chk("R3 fresh buffer data", 32'(data_bad), 32'd0);

      // R10 memory error
      put_desc(32'h300, 32'h400, 16'd8, 1'b1);
      cur_buf0 = 32'h400; cur_half0 = 4; dev_total = 4;
      err_en = 1'b1; err_addr = 32'h402;
      clear_logs();
      start(1'b0);
      wait_idle("R10 stops");
      err_en = 1'b0;
      reg_read(2'd1, r);
      chk("R10 error set", 32'(r[1]), 32'd1);
      chk("R10 failed word not acked", 32'(ack_cnt), 32'd1);

      // R12 write-one-to-clear of error
      reg_write(2'd1, 32'h0);
      reg_read(2'd1, r); chk("R12 zero write keeps error", 32'(r[1]), 32'd1);
      reg_write(2'd1, 32'h2);
      reg_read(2'd1, r); chk("R12 error cleared", 32'(r[1]), 32'd0);

      // R11 interrupt capture and clear
      @(negedge clk); dev_irq = 1'b1;
      @(negedge clk); dev_irq = 1'b0;
      reg_read(2'd1, r); chk("R11 interrupt set", 32'(r[2]), 32'd1);
      reg_write(2'd1, 32'h0);
      reg_read(2'd1, r); chk("R12 zero write keeps interrupt", 32'(r[2]), 32'd1);
      reg_write(2'd1, 32'h4);
      reg_read(2'd1, r); chk("R12 interrupt cleared", 32'(r[2]), 32'd0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule